// File: doc/BRIEF.md
# Timer Output Compare Channel Array

This block holds a set of output compare channels that all watch one shared free-running 31-bit time counter. The counter itself is outside the block and comes in as an input. Software arms a channel by writing a compare value. When the counter reaches that value, the channel raises its event flag. The channel can then signal an interrupt or a DMA request, and it moves its output pin in the way its mode field selects.

Each channel has a compare slot behind the visible one. A compare value written while the channel is enabled and armed waits in that slot. It takes over only after the pending value has matched. This lets software queue the following edge of a periodic waveform without racing the counter. Event flags are cleared by writing a one. A shared status word collects all event flags so that one read finds which channels fired.

Top module: `tcmp_array`

## Requirements
- R1: The status word sits at 0x604. Channel n has its control word at 0x608 + 8n and its compare word at 0x60C + 8n. Control word fields are: DMA request enable at bit 0, reserved bit 1 (always reads 0), mode at bits 5:2, interrupt enable at bit 6, and event flag at bit 7. A compare read returns the currently armed value in bits 30:0.
- R2: After reset every field, flag, compare value and pin reads zero, and irq_o and dma_req_o are low.
- R3: A channel with a nonzero mode and an armed compare value sets its event flag at the first clock edge at which cnt_i equals that value. The compare value is then consumed.
- R4: In mode 0x5, each match inverts the channel pin at that same edge.
- R5: In mode 0xF, each match drives the pin high for exactly one clock cycle.
- R6: Writing a control word with bit 7 set clears the event flag. Writing it with bit 7 clear leaves the flag as it is.
- R7: Status bits 3:0 show the event flags of channels 0 to 3. Writes to the status word have no effect.
- R8: irq_o is high while any channel has both its flag and its interrupt enable set. dma_req_o[n] is high while channel n has both its flag and its DMA request enable set.
- R9: A compare write to an enabled, armed channel is held as the next value. It becomes the armed value at the edge where the current value matches. Until then the compare read still returns the current value.
- R10: A compare write to a channel whose mode is zero, or that has no armed value, arms that value directly.
- R11: A control write whose mode field is zero disables the channel. It clears both the armed and the held compare values (the compare reads 0) and drives the pin low. The event flag is kept.
- R12: Compare values are 31 bits wide, and bit 31 of a compare write is dropped. Matches follow the counter through its wrap from 0x7FFFFFFF to 0.
- R13: A channel with mode zero never sets its flag, whatever cnt_i shows.
- R14: When a match and a flag-clearing control write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 31 | Shared time counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| pin_o | output | 4 | Per-channel compare output pins |
| dma_req_o | output | 4 | Per-channel DMA request |
| irq_o | output | 1 | Combined interrupt |

## Verification
A counter value presented before an edge affects the flags, pins, irq_o and dma_req_o at that edge. A register write lands at the edge that samples it. Read data is combinational, so it shows the state that has just been updated. The bench therefore drives each cycle's stimulus just after a falling edge and compares every output and the selected read word at the next falling edge, against a per-cycle expected state worked out from the requirements. Directed sequences place matches on exact counter values, including the wrap and a clear that lands on a match edge. A seeded random phase then sweeps the counter across the wrap while writes land at random points.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

   // control word field positions (software decodes these)
   localparam int CTL_DRE_BIT  = 0;
   localparam int CTL_MODE_LSB = 2;
   localparam int CTL_MODE_W   = 4;
   localparam int CTL_IE_BIT   = 6;
   localparam int CTL_FLAG_BIT = 7;
   localparam int CTL_W        = 8;

   // word offsets inside one channel slot, relative to the status word
   localparam int CTL_OFS = 4;
   localparam int CMP_OFS = 8;

   localparam logic [CTL_MODE_W-1:0] MODE_OFF    = 4'h0;
   localparam logic [CTL_MODE_W-1:0] MODE_TOGGLE = 4'h5;
   localparam logic [CTL_MODE_W-1:0] MODE_PULSE  = 4'hF;

endpackage

// File: rtl/tcmp_regdec.sv
module tcmp_regdec
   import tcmp_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int CNT_W       = 31,
   parameter int AW          = 12,
   parameter int DW          = 32,
   parameter int STATUS_ADDR = 'h604,
   parameter int CH_STRIDE   = 8
) (
   input  logic                  wr_en_i,
   input  logic [AW-1:0]         wr_addr_i,
   input  logic [AW-1:0]         rd_addr_i,
   input  logic [N_CH*CTL_W-1:0] ctl_rd_i,
   input  logic [N_CH*CNT_W-1:0] cmp_rd_i,
   input  logic [N_CH-1:0]       flags_i,
   output logic [N_CH-1:0]       ctl_we_o,
   output logic [N_CH-1:0]       cmp_we_o,
   output logic [DW-1:0]         rd_data_o
);

   localparam int CTL_BASE = STATUS_ADDR + CTL_OFS;
   localparam int CMP_BASE = STATUS_ADDR + CMP_OFS;

   for (genvar g = 0; g < N_CH; g++) begin : g_dec
      localparam int CTL_A = CTL_BASE + g * CH_STRIDE;
      localparam int CMP_A = CMP_BASE + g * CH_STRIDE;
      assign ctl_we_o[g] = wr_en_i && (wr_addr_i == AW'(CTL_A));
      assign cmp_we_o[g] = wr_en_i && (wr_addr_i == AW'(CMP_A));
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == AW'(STATUS_ADDR)) begin
         rd_data_o[N_CH-1:0] = flags_i;
      end
      for (int ch = 0; ch < N_CH; ch++) begin
         if (rd_addr_i == AW'(CTL_BASE + ch * CH_STRIDE)) begin
            rd_data_o[CTL_W-1:0] = ctl_rd_i[ch*CTL_W +: CTL_W];
         end
         if (rd_addr_i == AW'(CMP_BASE + ch * CH_STRIDE)) begin
            rd_data_o[CNT_W-1:0] = cmp_rd_i[ch*CNT_W +: CNT_W];
         end
      end
   end

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
   import tcmp_pkg::*;
#(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             ctl_we_i,
   input  logic             cmp_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CTL_W-1:0] ctl_rd_o,
   output logic [CNT_W-1:0] cmp_rd_o,
   output logic             flag_o,
   output logic             pin_o,
   output logic             irq_o,
   output logic             dma_o
);

   logic [CTL_MODE_W-1:0] mode_q;
   logic                  ie_q, dre_q, flag_q, pin_q;
   logic [CNT_W-1:0]      cur_q, nxt_q;
   logic                  cur_v_q, nxt_v_q;

   logic [CTL_MODE_W-1:0] wmode;
   logic                  wr_off, wr_clr, hit;

   assign wmode  = wdata_i[CTL_MODE_LSB +: CTL_MODE_W];
   assign wr_off = ctl_we_i && (wmode == MODE_OFF);
   assign wr_clr = ctl_we_i && wdata_i[CTL_FLAG_BIT];
   assign hit    = (mode_q != MODE_OFF) && cur_v_q && (cnt_i == cur_q);

   // control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         ie_q   <= 1'b0;
         dre_q  <= 1'b0;
      end else if (ctl_we_i) begin
         mode_q <= wmode;
         ie_q   <= wdata_i[CTL_IE_BIT];
         dre_q  <= wdata_i[CTL_DRE_BIT];
      end
   end

   // event flag: a match wins over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hit)    flag_q <= 1'b1;
      else if (wr_clr) flag_q <= 1'b0;
   end

   // armed value and held value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= '0;
         nxt_q   <= '0;
         cur_v_q <= 1'b0;
         nxt_v_q <= 1'b0;
      end else if (wr_off) begin
         cur_q   <= '0;
         nxt_q   <= '0;
         cur_v_q <= 1'b0;
         nxt_v_q <= 1'b0;
      end else if (hit) begin
         if (cmp_we_i && nxt_v_q) begin
            cur_q   <= nxt_q;
            nxt_q   <= wdata_i;
         end else if (cmp_we_i) begin
            cur_q   <= wdata_i;
         end else if (nxt_v_q) begin
            cur_q   <= nxt_q;
            nxt_v_q <= 1'b0;
         end else begin
            cur_v_q <= 1'b0;
         end
      end else if (cmp_we_i) begin
         if (mode_q == MODE_OFF || !cur_v_q) begin
            cur_q   <= wdata_i;
            cur_v_q <= 1'b1;
         end else begin
            nxt_q   <= wdata_i;
            nxt_v_q <= 1'b1;
         end
      end
   end

   // output pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (wr_off) begin
         pin_q <= 1'b0;
      end else if (hit) begin
         if (mode_q == MODE_TOGGLE)     pin_q <= ~pin_q;
         else if (mode_q == MODE_PULSE) pin_q <= 1'b1;
      end else if (mode_q == MODE_PULSE) begin
         pin_q <= 1'b0;
      end
   end

   assign ctl_rd_o = {flag_q, ie_q, mode_q, 1'b0, dre_q};
   assign cmp_rd_o = cur_q;
   assign flag_o   = flag_q;
   assign pin_o    = pin_q;
   assign irq_o    = flag_q && ie_q;
   assign dma_o    = flag_q && dre_q;

   // R3
   hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);

   // R5
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_q && mode_q == MODE_PULSE && $past(mode_q) == MODE_PULSE) |-> $past(hit));

   // R6
   flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(wr_clr));

   // R11
   disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off |=> (!pin_q && !cur_v_q && !nxt_v_q));

   // R13
   off_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |=> !$rose(flag_q));

endmodule

// File: rtl/tcmp_array.sv
module tcmp_array
   import tcmp_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int CNT_W       = 31,
   parameter int AW          = 12,
   parameter int DW          = 32,
   parameter int STATUS_ADDR = 'h604,
   parameter int CH_STRIDE   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [DW-1:0]    wr_data_i,
   input  logic [AW-1:0]    rd_addr_i,
   output logic [DW-1:0]    rd_data_o,
   output logic [N_CH-1:0]  pin_o,
   output logic [N_CH-1:0]  dma_req_o,
   output logic             irq_o
);

   localparam int LAST_ADDR = STATUS_ADDR + CMP_OFS + (N_CH - 1) * CH_STRIDE;

   if (CNT_W < CTL_W || CNT_W > DW) begin : g_bad_cnt_w
      $error("tcmp_array: CNT_W must lie between the control width and DW");
   end
   if (N_CH < 1 || N_CH > DW) begin : g_bad_n_ch
      $error("tcmp_array: N_CH must lie between 1 and DW");
   end
   if (CH_STRIDE < CMP_OFS) begin : g_bad_stride
      $error("tcmp_array: CH_STRIDE too small for two words per channel");
   end
   if (LAST_ADDR >= (1 << AW)) begin : g_bad_map
      $error("tcmp_array: register map does not fit in AW bits");
   end

   if (DW > CNT_W) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DW-1:CNT_W];
   end

   logic [N_CH-1:0]       ctl_we, cmp_we, flags, irq_each;
   logic [N_CH*CTL_W-1:0] ctl_rd;
   logic [N_CH*CNT_W-1:0] cmp_rd;

   tcmp_regdec #(
      .N_CH(N_CH), .CNT_W(CNT_W), .AW(AW), .DW(DW),
      .STATUS_ADDR(STATUS_ADDR), .CH_STRIDE(CH_STRIDE)
   ) u_dec (
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .rd_addr_i(rd_addr_i),
      .ctl_rd_i (ctl_rd),
      .cmp_rd_i (cmp_rd),
      .flags_i  (flags),
      .ctl_we_o (ctl_we),
      .cmp_we_o (cmp_we),
      .rd_data_o(rd_data_o)
   );

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      tcmp_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt_i   (cnt_i),
         .ctl_we_i(ctl_we[g]),
         .cmp_we_i(cmp_we[g]),
         .wdata_i (wr_data_i[CNT_W-1:0]),
         .ctl_rd_o(ctl_rd[g*CTL_W +: CTL_W]),
         .cmp_rd_o(cmp_rd[g*CNT_W +: CNT_W]),
         .flag_o  (flags[g]),
         .pin_o   (pin_o[g]),
         .irq_o   (irq_each[g]),
         .dma_o   (dma_req_o[g])
      );
   end

   assign irq_o = |irq_each;

   // R8
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|flags));

   // R8
   dma_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req_o & ~flags) == '0);

endmodule

// File: tb/tcmp_array_tb_top.sv
`timescale 1ns/1ps
module tcmp_array_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [30:0] cnt = '0;
   logic        wen = 1'b0;
   logic [11:0] waddr = '0;
   logic [31:0] wdata = '0;
   logic [11:0] raddr = 12'h604;
   logic [31:0] rdata;
   logic [3:0]  pin, dma;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tcmp_array dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
      .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
      .rd_addr_i(raddr), .rd_data_o(rdata),
      .pin_o(pin), .dma_req_o(dma), .irq_o(irq)
   );

   // expected state, built from the requirements
   logic [3:0]  m_mode [4];
   logic        m_ie [4], m_dre [4], m_flag [4], m_pin [4], m_cv [4], m_nv [4];
   logic [30:0] m_cur [4], m_nxt [4];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [31:0] r = '0;
      if (a == 12'h604) for (int c = 0; c < 4; c++) r[c] = m_flag[c];
      for (int c = 0; c < 4; c++) begin
         if (a == 12'h608 + 12'(8*c)) r[7:0] = {m_flag[c], m_ie[c], m_mode[c], 1'b0, m_dre[c]};
         if (a == 12'h60C + 12'(8*c)) r[30:0] = m_cur[c];
      end
      return r;
   endfunction

   function automatic string read_tag(input logic [11:0] a);
      if (a == 12'h604) return "R7";
      if (a[2]) return "R9";
      return "R1";
   endfunction

   task automatic mdl_step(input bit we, input logic [11:0] a, input logic [31:0] d, input logic [30:0] c);
      for (int ch = 0; ch < 4; ch++) begin
         bit hit, kw, cw, off;
         logic [3:0] om;
         om  = m_mode[ch];
         hit = (om != 4'h0) && m_cv[ch] && (c == m_cur[ch]);
         kw  = we && (a == 12'h608 + 12'(8*ch));
         cw  = we && (a == 12'h60C + 12'(8*ch));
         off = kw && (d[5:2] == 4'h0);
         if (off) m_pin[ch] = 1'b0;
         else if (hit) begin
            if (om == 4'h5) m_pin[ch] = ~m_pin[ch];
            else if (om == 4'hF) m_pin[ch] = 1'b1;
         end else if (om == 4'hF) m_pin[ch] = 1'b0;
         if (hit) m_flag[ch] = 1'b1;
         else if (kw && d[7]) m_flag[ch] = 1'b0;
         if (off) begin
            m_cur[ch] = '0; m_nxt[ch] = '0; m_cv[ch] = 1'b0; m_nv[ch] = 1'b0;
         end else if (hit) begin
            if (cw && m_nv[ch]) begin m_cur[ch] = m_nxt[ch]; m_nxt[ch] = d[30:0]; end
            else if (cw) m_cur[ch] = d[30:0];
            else if (m_nv[ch]) begin m_cur[ch] = m_nxt[ch]; m_nv[ch] = 1'b0; end
            else m_cv[ch] = 1'b0;
         end else if (cw) begin
            if (om == 4'h0 || !m_cv[ch]) begin m_cur[ch] = d[30:0]; m_cv[ch] = 1'b1; end
            else begin m_nxt[ch] = d[30:0]; m_nv[ch] = 1'b1; end
         end
         if (kw) begin m_mode[ch] = d[5:2]; m_ie[ch] = d[6]; m_dre[ch] = d[0]; end
      end
   endtask

   task automatic compare_all();
      logic eirq = 1'b0;
      for (int ch = 0; ch < 4; ch++) begin
         string t;
         t = (m_mode[ch] == 4'h5) ? "R4" : (m_mode[ch] == 4'hF) ? "R5" : "R11";
         chk(pin[ch] == m_pin[ch], t, 32'(pin[ch]), 32'(m_pin[ch]));
         chk(dma[ch] == (m_flag[ch] && m_dre[ch]), "R8", 32'(dma[ch]), 32'(m_flag[ch] && m_dre[ch]));
         eirq = eirq | (m_flag[ch] && m_ie[ch]);
      end
      chk(irq == eirq, "R8", 32'(irq), 32'(eirq));
      chk(rdata == exp_read(raddr), read_tag(raddr), rdata, exp_read(raddr));
   endtask

   // one clock: inputs driven after a falling edge, outputs checked at the next
   task automatic tick(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input logic [30:0] c, input logic [11:0] ra);
      wen = we; waddr = a; wdata = d; cnt = c; raddr = ra;
      mdl_step(we, a, d, c);
      @(posedge clk);
      @(negedge clk);
      wen = 1'b0;
      compare_all();
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [30:0] c);
      tick(1'b1, a, d, c, 12'h604);
   endtask

   task automatic run(input logic [30:0] from, input int n, input logic [11:0] ra);
      for (int i = 0; i < n; i++) tick(1'b0, 12'h0, 32'h0, from + 31'(i), ra);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi_cnt;
      logic [30:0] c;
      for (int ch = 0; ch < 4; ch++) begin
         m_mode[ch] = '0; m_ie[ch] = 0; m_dre[ch] = 0; m_flag[ch] = 0; m_pin[ch] = 0;
         m_cv[ch] = 0; m_nv[ch] = 0; m_cur[ch] = '0; m_nxt[ch] = '0;
      end
      void'($urandom(32'd20517));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      chk(pin == 4'h0 && dma == 4'h0 && irq == 1'b0, "R2", {23'h0, irq, dma, pin}, 32'h0);
      chk(rdata == 32'h0, "R2", rdata, 32'h0);
      raddr = 12'h60C; #1;
      chk(rdata == 32'h0, "R2", rdata, 32'h0);
      @(negedge clk);

      // channel 0: direct arm while off, then toggle mode with irq enable
      wr(12'h60C, 32'd100, 31'd10);
      tick(1'b0, 12'h0, 0, 31'd11, 12'h60C);
      chk(rdata == 32'd100, "R10", rdata, 32'd100);
      wr(12'h608, 32'h54, 31'd12);
      run(31'd97, 3, 12'h604);
      chk(rdata[0] == 1'b0, "R3", rdata, 32'h0);
      tick(1'b0, 12'h0, 0, 31'd100, 12'h604);
      chk(rdata[0] == 1'b1, "R3", rdata, 32'h1);
      chk(pin[0] == 1'b1, "R4", 32'(pin[0]), 32'h1);
      chk(irq == 1'b1, "R8", 32'(irq), 32'h1);
      // consumed value: no second event on the same counter value
      wr(12'h608, 32'hD4, 31'd100);
      tick(1'b0, 12'h0, 0, 31'd100, 12'h604);
      chk(rdata[0] == 1'b0, "R3", rdata, 32'h0);
      // fired with nothing held: next write arms directly, following one is held
      wr(12'h60C, 32'd110, 31'd101);
      wr(12'h60C, 32'd120, 31'd102);
      tick(1'b0, 12'h0, 0, 31'd103, 12'h60C);
      chk(rdata == 32'd110, "R9", rdata, 32'd110);
      run(31'd104, 7, 12'h60C);
      chk(pin[0] == 1'b0, "R4", 32'(pin[0]), 32'h0);
      chk(rdata == 32'd120, "R9", rdata, 32'd120);
      run(31'd111, 10, 12'h604);
      chk(pin[0] == 1'b1, "R4", 32'(pin[0]), 32'h1);

      // write-1-to-clear
      wr(12'h608, 32'h54, 31'd130);
      chk(rdata[0] == 1'b1, "R6", rdata, 32'h1);
      wr(12'h608, 32'hD4, 31'd131);
      chk(rdata[0] == 1'b0, "R6", rdata, 32'h0);

      // channel 1: high pulse with DMA request
      wr(12'h614, 32'd200, 31'd140);
      wr(12'h610, 32'h3D, 31'd141);
      run(31'd198, 2, 12'h604);
      tick(1'b0, 12'h0, 0, 31'd200, 12'h604);
      chk(pin[1] == 1'b1, "R5", 32'(pin[1]), 32'h1);
      chk(dma[1] == 1'b1, "R8", 32'(dma[1]), 32'h1);
      tick(1'b0, 12'h0, 0, 31'd201, 12'h604);
      chk(pin[1] == 1'b0, "R5", 32'(pin[1]), 32'h0);
      // status writes are ignored
      wr(12'h604, 32'hFFFF_FFFF, 31'd202);
      chk(rdata[3:0] == 4'h2, "R7", rdata, 32'h2);

      // channel 2: wrap, bit 31 of the write dropped
      wr(12'h61C, 32'hFFFF_FFFF, 31'd210);
      wr(12'h618, 32'h14, 31'd211);
      wr(12'h61C, 32'h0, 31'd212);
      tick(1'b0, 12'h0, 0, 31'h7FFF_FFFE, 12'h61C);
      chk(rdata == 32'h7FFF_FFFF, "R12", rdata, 32'h7FFF_FFFF);
      tick(1'b0, 12'h0, 0, 31'h7FFF_FFFF, 12'h604);
      chk(pin[2] == 1'b1, "R12", 32'(pin[2]), 32'h1);
      tick(1'b0, 12'h0, 0, 31'h0, 12'h604);
      chk(pin[2] == 1'b0 && rdata[2] == 1'b1, "R12", {pin[2], rdata[30:0]}, 32'h4);

      // channel 3: disable drops the held value and the pin
      wr(12'h624, 32'd300, 31'd250);
      wr(12'h620, 32'h14, 31'd251);
      wr(12'h624, 32'd305, 31'd252);
      run(31'd299, 2, 12'h604);
      chk(pin[3] == 1'b1, "R4", 32'(pin[3]), 32'h1);
      wr(12'h620, 32'h0, 31'd301);
      chk(pin[3] == 1'b0 && rdata[3] == 1'b1, "R11", {pin[3], rdata[30:0]}, 32'h8);
      tick(1'b0, 12'h0, 0, 31'd302, 12'h624);
      chk(rdata == 32'h0, "R11", rdata, 32'h0);
      wr(12'h620, 32'h80, 31'd303);
      run(31'd304, 4, 12'h604);
      chk(rdata[3] == 1'b0 && pin[3] == 1'b0, "R13", {pin[3], rdata[30:0]}, 32'h0);

      // channel 0: clear on the match edge loses to the event
      wr(12'h60C, 32'd400, 31'd390);
      tick(1'b1, 12'h608, 32'hD4, 31'd400, 12'h604);
      chk(rdata[0] == 1'b1, "R14", rdata, 32'h1);

      // random phase across the wrap
      c = 31'h7FFF_FE00;
      for (int i = 0; i < 4000; i++) begin
         int sel, ch;
         logic [31:0] d;
         logic [11:0] ra;
         sel = int'($urandom % 100);
         ch  = int'($urandom % 4);
         case ($urandom % 3)
            0: ra = 12'h604;
            1: ra = 12'h608 + 12'(8*($urandom % 4));
            default: ra = 12'h60C + 12'(8*($urandom % 4));
         endcase
         if (sel < 8) begin
            d = '0;
            case ($urandom % 6)
               0: d[5:2] = 4'h0;
               1, 2: d[5:2] = 4'h5;
               3, 4: d[5:2] = 4'hF;
               default: d[5:2] = 4'h3;
            endcase
            d[7] = 1'($urandom); d[6] = 1'($urandom); d[1] = 1'($urandom); d[0] = 1'($urandom);
            tick(1'b1, 12'h608 + 12'(8*ch), d, c, ra);
         end else if (sel < 20) begin
            d = {1'($urandom), c + 31'(1 + $urandom % 12)};
            tick(1'b1, 12'h60C + 12'(8*ch), d, c, ra);
         end else if (sel < 23) begin
            tick(1'b1, 12'h604, $urandom, c, ra);
         end else begin
            tick(1'b0, 12'h0, 0, c, ra);
         end
         c = c + 31'd1;
      end
      hi_cnt = checks;
      $display("Simulation finished: %0d checks, %0d errors", hi_cnt, errors);
      $finish;
   end

endmodule